// File: doc/BRIEF.md
# Seconds Alarm Comparator with Sticky Status, Interrupt and Pin Select

This block watches a running seconds count. On each seconds tick it compares the count with a programmed 32-bit alarm value. A match while the alarm is enabled sets a sticky alarm flag. If the output pin is routed to the alarm at that moment, a second flag is also set, and it keeps the pin high. A separate input pulse reports a slow or missing low-frequency clock and sets a third sticky flag. Software clears flags by writing ones to them.

The interrupt line is a level. It is the OR, over the alarm and clock-error sources, of each flag ANDed with its enable bit. A 2-bit select in the control byte picks what the single output pin carries: nothing, a plain level, the latched alarm flag, or the slow clock. Counting, calibration and register decode are not part of this block; its inputs arrive already decoded.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, `status_o` is 0, `irq_o` is 0 and `pin_o` is 0 (select field reset value comes from `ctrl_i`; with `ctrl_i`=0 the pin is low).
- R2: When `sec_tick_i` is 1, control bit 2 (alarm enable) is 1 and `sec_count_i` equals `alarm_val_i`, status bit 0 is 1 from the next rising clock edge on.
- R3: Status bit 0 is not set when control bit 2 is 0, when `sec_tick_i` is 0, or when the count differs from the alarm value.
- R4: Status bit 1 is set on a match (as in R2) only if control bits 5:4 equal 2 at that cycle; otherwise a match leaves it unchanged.
- R5: A one-cycle `clk_err_i` pulse sets status bit 2 from the next clock edge on.
- R6: Status bits hold their value until cleared. A cycle with `w1c_valid_i`=1 clears exactly the bits whose `w1c_mask_i` bit is 1; mask bits of 0 and cycles with `w1c_valid_i`=0 leave the bits unchanged. Status bits 7:3 always read 0.
- R7: If a set event and a clear hit the same status bit in one cycle, the bit is 1 afterwards.
- R8: `irq_o` equals (status bit 0 AND enable bit 0) OR (status bit 2 AND enable bit 2). Status bit 1 and enable bits other than 0 and 2 have no effect on it. It follows status and enables in the same cycle.
- R9: `pin_o` depends on control bits 5:4. A value of 0 drives 0. A value of 1 drives `pin_level_i`. A value of 2 drives status bit 1. A value of 3 drives `slow_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_count_i | input | 32 | Running seconds count |
| sec_tick_i | input | 1 | One-cycle pulse when the seconds count advances |
| alarm_val_i | input | 32 | Programmed alarm seconds value |
| ctrl_i | input | 8 | Control byte: bit 2 alarm enable, bits 5:4 pin select |
| irq_en_i | input | 8 | Interrupt enables: bit 0 alarm, bit 2 clock error |
| clk_err_i | input | 1 | One-cycle slow-clock error pulse |
| w1c_valid_i | input | 1 | Write-one-to-clear strobe |
| w1c_mask_i | input | 8 | Bits to clear when the strobe is high |
| pin_level_i | input | 1 | Level driven on the pin in plain-output mode |
| slow_clk_i | input | 1 | Slow clock routed to the pin in clock mode |
| status_o | output | 8 | Sticky status byte |
| irq_o | output | 1 | Level interrupt |
| pin_o | output | 1 | Multiplexed output pin |

## Verification
Status flags are registered, so a tick, error pulse or clear shows up one rising edge after the cycle that presents it. The interrupt and the pin are combinational from status and the present inputs, so they respond in that same cycle. The bench drives every input a short delay after a rising edge and holds it through the next rising edge. It samples 2 ns after that edge. It keeps a model of the status byte that it updates once per edge from the requirement equations and compares all three outputs on every cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ST_W      = 3;
  localparam int ST_ALARM  = 0;
  localparam int ST_PIN    = 1;
  localparam int ST_CLKERR = 2;
  localparam int CTL_AEN   = 2;
  localparam int SEL_LSB   = 4;

  typedef enum logic [1:0] {
    PIN_OFF     = 2'd0,
    PIN_LEVEL   = 2'd1,
    PIN_ALARM   = 2'd2,
    PIN_SLOWCLK = 2'd3
  } pin_sel_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] alarm_i,
  input  logic             tick_i,
  input  logic             en_i,
  output logic             hit_o
);
  // compare only on the tick so a held match fires once
  assign hit_o = tick_i & en_i & (count_i == alarm_i);
endmodule

// File: rtl/status_sticky.sv
module status_sticky #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[b]) q <= 1'b1;   // set beats clear
      else if (clr_i[b]) q <= 1'b0;
    end
    assign q_o[b] = q;

    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[b]) |=> q);
    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[b] && clr_i[b]) |=> q);
    // R6
    no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!q && !set_i[b]) |=> !q);
  end
endmodule

// File: rtl/pin_select.sv
module pin_select
  import rtc_alarm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_sel_e sel_i,
  input  logic     level_i,
  input  logic     alarm_flag_i,
  input  logic     slow_clk_i,
  output logic     pin_o
);
  always_comb begin
    unique case (sel_i)
      PIN_LEVEL:   pin_o = level_i;
      PIN_ALARM:   pin_o = alarm_flag_i;
      PIN_SLOWCLK: pin_o = slow_clk_i;
      default:     pin_o = 1'b0;
    endcase
  end

  // R9
  pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == PIN_OFF) |-> !pin_o);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] sec_count_i,
  input  logic             sec_tick_i,
  input  logic [CNT_W-1:0] alarm_val_i,
  input  logic [7:0]       ctrl_i,
  input  logic [7:0]       irq_en_i,
  input  logic             clk_err_i,
  input  logic             w1c_valid_i,
  input  logic [7:0]       w1c_mask_i,
  input  logic             pin_level_i,
  input  logic             slow_clk_i,
  output logic [7:0]       status_o,
  output logic             irq_o,
  output logic             pin_o
);
  localparam int PAD_W = 8 - ST_W;

  logic            hit;
  pin_sel_e        sel;
  logic [ST_W-1:0] set_v, clr_v, st, src_en;

  assign sel = pin_sel_e'(ctrl_i[SEL_LSB+1:SEL_LSB]);

  alarm_match #(.CNT_W(CNT_W)) u_match (
    .count_i (sec_count_i),
    .alarm_i (alarm_val_i),
    .tick_i  (sec_tick_i),
    .en_i    (ctrl_i[CTL_AEN]),
    .hit_o   (hit)
  );

  always_comb begin
    set_v            = '0;
    set_v[ST_ALARM]  = hit;
    set_v[ST_PIN]    = hit && (sel == PIN_ALARM);
    set_v[ST_CLKERR] = clk_err_i;
  end

  assign clr_v = w1c_valid_i ? w1c_mask_i[ST_W-1:0] : '0;

  status_sticky #(.W(ST_W)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (st)
  );

  always_comb begin
    src_en            = '0;
    src_en[ST_ALARM]  = irq_en_i[0];
    src_en[ST_CLKERR] = irq_en_i[2];
  end

  assign irq_o    = |(st & src_en);
  assign status_o = {{PAD_W{1'b0}}, st};

  pin_select u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel),
    .level_i      (pin_level_i),
    .alarm_flag_i (st[ST_PIN]),
    .slow_clk_i   (slow_clk_i),
    .pin_o        (pin_o)
  );

  // R2
  match_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && ctrl_i[CTL_AEN] && (sec_count_i == alarm_val_i)) |=> status_o[ST_ALARM]);
  // R3
  alarm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[CTL_AEN] && !status_o[ST_ALARM]) |=> !status_o[ST_ALARM]);
  // R4
  pin_flag_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_i[SEL_LSB+1:SEL_LSB] != 2'd2) && !status_o[ST_PIN]) |=> !status_o[ST_PIN]);
  // R5
  clkerr_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_err_i |=> status_o[ST_CLKERR]);
  // R8
  irq_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_ALARM] && irq_en_i[0]) |-> irq_o);
  // R8
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[ST_ALARM] && !status_o[ST_CLKERR]) |-> !irq_o);
  // R9
  pin_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[SEL_LSB+1:SEL_LSB] == 2'd2) |-> (pin_o == status_o[ST_PIN]));
  // R6
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:ST_W] == '0);
endmodule

// File: tb/rtc_alarm_unit_tb.sv
module rtc_alarm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt = '0, alm = '0;
  logic        tick = 1'b0, cerr = 1'b0, wv = 1'b0, lvl = 1'b0, sclk = 1'b0;
  logic [7:0]  ctrl = '0, ien = '0, wm = '0;
  logic [7:0]  status;
  logic        irq, pin;
  logic [2:0]  exp_st = '0;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  rtc_alarm_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sec_count_i(cnt), .sec_tick_i(tick),
    .alarm_val_i(alm), .ctrl_i(ctrl), .irq_en_i(ien), .clk_err_i(cerr),
    .w1c_valid_i(wv), .w1c_mask_i(wm), .pin_level_i(lvl), .slow_clk_i(sclk),
    .status_o(status), .irq_o(irq), .pin_o(pin)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_pin();
    case (ctrl[5:4])
      2'd1:    return lvl;
      2'd2:    return exp_st[1];
      2'd3:    return sclk;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_outs(input string req);
    chk({req, " status"}, status, {5'b0, exp_st});
    chk("R8 irq", {7'b0, irq}, {7'b0, (exp_st[0] & ien[0]) | (exp_st[2] & ien[2])});
    chk("R9 pin", {7'b0, pin}, {7'b0, exp_pin()});
  endtask

  // one clock: model update from requirement equations, pulses dropped after the edge
  task automatic cycle(input string req);
    logic       hit;
    logic [2:0] set_v, clr_v;
    hit   = tick & ctrl[2] & (cnt == alm);
    set_v = {cerr, hit & (ctrl[5:4] == 2'd2), hit};
    clr_v = wv ? wm[2:0] : 3'b0;
    @(posedge clk);
    #2;
    exp_st = (exp_st & ~clr_v) | set_v;
    tick = 1'b0; cerr = 1'b0; wv = 1'b0; wm = '0;
    check_outs(req);
  endtask

  task automatic clear_all();
    wv = 1'b1; wm = 8'hFF;
    cycle("R6 clear");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #23;
    check_outs("R1 in reset");
    rst_n = 1'b1;
    cycle("R1 after reset");

    // R2 R3 R4 sweep: select x enable x equal x tick
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        for (int e = 0; e < 2; e++)
          for (int t = 0; t < 2; t++) begin
            ctrl = {2'b0, 2'(s), 1'b0, 1'(a), 2'b0};
            cnt  = 32'hFFFF_0000 + 32'(s * 8 + a * 4 + e * 2 + t);
            alm  = e ? cnt : cnt ^ 32'h8000_0000;
            tick = 1'(t);
            cycle("R2 R3 R4 match");
            cycle("R6 hold");
            clear_all();
          end

    // R5 clock error, then R8 enable sweep with all flags set
    ctrl = 8'h24; cnt = 32'd77; alm = 32'd77; tick = 1'b1; cerr = 1'b1;
    cycle("R5 R4 set all");
    for (int m = 0; m < 256; m += 5) begin
      ien = 8'(m);
      cycle("R8 enables");
    end
    ien = 8'h05;

    // R6 writing zero and valid-low masks do nothing
    wv = 1'b1; wm = 8'h00; cycle("R6 zero mask");
    wv = 1'b0; wm = 8'hFF; cycle("R6 no strobe");
    // R6 partial clears, R9 pin drops with bit 1
    wv = 1'b1; wm = 8'h02; cycle("R6 clear bit1");
    wv = 1'b1; wm = 8'hF9; cycle("R6 clear bits");

    // R7 set wins over clear
    tick = 1'b1; wv = 1'b1; wm = 8'h07; cycle("R7 alarm set wins");
    cerr = 1'b1; wv = 1'b1; wm = 8'h04; cycle("R7 clkerr set wins");
    clear_all();

    // R9 plain level and slow clock modes
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 4; v++) begin
        ctrl = {2'b0, 2'(s), 4'b0};
        lvl = v[0]; sclk = v[1];
        cycle("R9 pin mux");
      end

    // R3 held equality without further ticks sets once only
    ctrl = 8'h04; cnt = 32'd9; alm = 32'd9; tick = 1'b1;
    cycle("R2 single tick");
    clear_all();
    cycle("R3 no retrigger");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule